// File: doc/BRIEF.md
# Sample-Based Amplitude and Offset Estimator

This block sits behind the phase detector of a twice-per-bit sampling receiver. It watches the demultiplexed sample streams and produces two slowly varying control words for the analog front end. The first word tracks the signal amplitude and feeds the gain control. The second word tracks the DC offset and feeds the offset correction. Both words go to DACs outside this block.

The amplitude estimate uses the mid-bit data samples. Each accepted sample's magnitude is taken and folded into a first-order leaky average. The offset estimate uses the boundary samples, which sit between two bits. A boundary sample is accepted only when the phase detector flags a real transition. At such a crossing the ideal value is zero, so the signed mean of these samples measures the offset.

Each average runs in a fixed-point accumulator with 2^SHW-1 fraction bits. A 4-bit shift input per channel sets the time constant.

Top module: `amp_ofs_est`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is `amp_level` = 0 and `ofs_level` = the offset-binary midscale code (MSB set, other bits zero, 0x80 for W=8).
- R2: Sample codes are offset binary: signed value = code − 2^(W−1). The magnitude of code 0 is 2^(W−1) (128 for W=8). The magnitude of the midscale code is 0.
- R3: When `smp_valid` is high at a rising edge, the amplitude accumulator A becomes A + ((|s|·2^F − A) >>> `amp_shift`), where F = 2^SHW−1 (15 by default). `amp_level` is A >> F and is visible right after that edge. With shift 0, `amp_level` equals |s| of the last accepted sample.
- R4: When `smp_valid` is low, `amp_level` holds its value.
- R5: When `smp_valid` and `edge_seen` are both high at a rising edge, the signed offset accumulator O becomes O + ((p·2^F − O) >>> `ofs_shift`), where p is the signed value of `phase_smp`. The shift is arithmetic, so it rounds toward minus infinity.
- R6: `ofs_level` is floor(O / 2^F) written in offset binary (its MSB inverted). It changes only when `smp_valid` and `edge_seen` are both high. A `phase_smp` without a flagged transition has no effect.
- R7: Both accumulators saturate rather than wrap. `amp_level` never exceeds 2^(W−1). `ofs_level` stays within the full code range.
- R8: The shift values are taken afresh at every update, so a time constant can change between two samples without any other effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Data and phase samples are valid this cycle |
| data_smp | input | W | Mid-bit data sample, offset binary |
| phase_smp | input | W | Boundary sample, offset binary |
| edge_seen | input | 1 | Phase detector saw a transition around this boundary |
| amp_shift | input | SHW | Amplitude averaging shift |
| ofs_shift | input | SHW | Offset averaging shift |
| amp_level | output | W | Averaged magnitude, unsigned |
| ofs_level | output | W | Averaged offset, offset binary |

## Verification
The bench builds the block with its defaults: W=8 and SHW=4, which gives 15 fraction bits. At these values the full code range can be driven, including both extreme codes and midscale. The shift range 0 to 15 is also reachable. Shift 0 makes each output snap to the latest sample, so fixed vectors can be checked directly. Larger shifts expose the fractional decay and the floor rounding of negative offsets, and the bench checks these against a reference model written in long integers.

// File: rtl/amp_ofs_est.sv
module amp_ofs_est #(
  parameter int W   = 8,
  parameter int SHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  input  logic [W-1:0]   data_smp,
  input  logic [W-1:0]   phase_smp,
  input  logic           edge_seen,
  input  logic [SHW-1:0] amp_shift,
  input  logic [SHW-1:0] ofs_shift,
  output logic [W-1:0]   amp_level,
  output logic [W-1:0]   ofs_level
);
  localparam int FRAC = (1 << SHW) - 1;
  localparam int AW   = W + FRAC;
  localparam int DW   = AW + 2;
  localparam logic signed [DW-1:0] AMP_MAX = DW'(1) << (W - 1 + FRAC);
  localparam logic signed [DW-1:0] OFS_MAX = (DW'(1) << (AW - 1)) - DW'(1);
  localparam logic signed [DW-1:0] OFS_MIN = -(DW'(1) << (AW - 1));

  logic [W-1:0]         d_s, d_abs;
  logic [AW-1:0]        amp_acc;
  logic signed [AW-1:0] ofs_acc;
  logic signed [DW-1:0] amp_diff, amp_sum, ofs_diff, ofs_sum;
  logic [AW-1:0]        amp_nxt;
  logic signed [AW-1:0] ofs_nxt;

  assign d_s   = {~data_smp[W-1], data_smp[W-2:0]};
  assign d_abs = d_s[W-1] ? (~d_s + 1'b1) : d_s;

  assign amp_diff = $signed({2'b00, d_abs, {FRAC{1'b0}}}) - $signed({2'b00, amp_acc});
  assign amp_sum  = $signed({2'b00, amp_acc}) + (amp_diff >>> amp_shift);

  assign ofs_diff = $signed({{2{~phase_smp[W-1]}}, ~phase_smp[W-1], phase_smp[W-2:0], {FRAC{1'b0}}})
                  - $signed({{2{ofs_acc[AW-1]}}, ofs_acc});
  assign ofs_sum  = $signed({{2{ofs_acc[AW-1]}}, ofs_acc}) + (ofs_diff >>> ofs_shift);

  always_comb begin
    if (amp_sum < 0)             amp_nxt = '0;
    else if (amp_sum > AMP_MAX)  amp_nxt = AMP_MAX[AW-1:0];
    else                         amp_nxt = amp_sum[AW-1:0];
    if (ofs_sum < OFS_MIN)       ofs_nxt = OFS_MIN[AW-1:0];
    else if (ofs_sum > OFS_MAX)  ofs_nxt = OFS_MAX[AW-1:0];
    else                         ofs_nxt = ofs_sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amp_acc <= '0;
      ofs_acc <= '0;
    end else if (smp_valid) begin
      amp_acc <= amp_nxt;
      if (edge_seen) ofs_acc <= ofs_nxt;
    end
  end

  assign amp_level = amp_acc[AW-1:FRAC];
  assign ofs_level = {~ofs_acc[AW-1], ofs_acc[AW-2:FRAC]};
endmodule

// File: rtl/amp_ofs_est_chk.sv
module amp_ofs_est_chk #(
  parameter int W   = 8,
  parameter int SHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_valid,
  input logic [W-1:0]   data_smp,
  input logic [W-1:0]   phase_smp,
  input logic           edge_seen,
  input logic [SHW-1:0] amp_shift,
  input logic [SHW-1:0] ofs_shift,
  input logic [W-1:0]   amp_level,
  input logic [W-1:0]   ofs_level
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mag_in;
  assign mag_in = data_smp[W-1] ? {1'b0, data_smp[W-2:0]} : (MID - data_smp);

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (amp_level == '0 && ofs_level == MID)); // R1
  AST_AMP_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && amp_shift == '0) |=> amp_level == $past(mag_in)); // R3
  AST_AMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(amp_level)); // R4
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && edge_seen) |=> $stable(ofs_level)); // R6
  AST_OFS_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && edge_seen && ofs_shift == '0) |=> ofs_level == $past(phase_smp)); // R5
  AST_AMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    amp_level <= MID); // R7
endmodule

bind amp_ofs_est amp_ofs_est_chk #(.W(W), .SHW(SHW)) u_chk (.*);

// File: tb/amp_ofs_est_test.sv
module amp_ofs_est_test;
  logic clk = 0, rst_n = 0, smp_valid = 0, edge_seen = 0;
  logic [7:0] data_smp = 8'h80, phase_smp = 8'h80, amp_level, ofs_level;
  logic [3:0] amp_shift = 0, ofs_shift = 0;
  int errors = 0, checks = 0;
  longint am, om;

  always #2 clk = ~clk;

  amp_ofs_est uut (.*);

  // {valid, edge, data, phase, exp_amp, exp_ofs}, shifts 0 (R2, R3, R4, R5, R6)
  localparam logic [33:0] VEC [8] = '{
    {1'b1,1'b1,8'hA0,8'h83,8'd32, 8'h83},
    {1'b1,1'b0,8'h40,8'h90,8'd64, 8'h83},
    {1'b0,1'b1,8'hFF,8'h10,8'd64, 8'h83},
    {1'b1,1'b1,8'h00,8'h7C,8'd128,8'h7C},
    {1'b1,1'b1,8'h80,8'h80,8'd0,  8'h80},
    {1'b1,1'b1,8'hFF,8'h00,8'd127,8'h00},
    {1'b1,1'b1,8'h7F,8'hFF,8'd1,  8'hFF},
    {1'b0,1'b0,8'h12,8'h34,8'd1,  8'hFF}};

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic longint upd(longint acc, longint x, int k, longint lo, longint hi);
    longint n = acc + (((x <<< 15) - acc) >>> k);
    return n < lo ? lo : (n > hi ? hi : n);
  endfunction

  task automatic step(logic v, logic e, logic [7:0] d, logic [7:0] p);
    smp_valid = v; edge_seen = e; data_smp = d; phase_smp = p;
    @(negedge clk);
    if (v) begin
      am = upd(am, (d >= 128) ? longint'(d) - 128 : 128 - longint'(d), int'(amp_shift), 0, 128 <<< 15);
      if (e) om = upd(om, longint'(p) - 128, int'(ofs_shift), -(128 <<< 15), (128 <<< 15) - 1);
    end
  endtask

  task automatic chk_model(string req);
    chk(req, amp_level, 8'(am >>> 15));
    chk(req, ofs_level, 8'((om >>> 15) + 128));
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 amp reset", amp_level, 8'h00);
    chk("R1 ofs reset", ofs_level, 8'h80);
    rst_n = 1;
    am = 0; om = 0;
    foreach (VEC[i]) begin
      step(VEC[i][33], VEC[i][32], VEC[i][31:24], VEC[i][23:16]);
      chk("R3 R4 vec amp", amp_level, VEC[i][15:8]);
      chk("R5 R6 vec ofs", ofs_level, VEC[i][7:0]);
    end
    // R1 reset mid-run
    rst_n = 0; @(negedge clk);
    chk("R1 amp rerst", amp_level, 8'h00);
    chk("R1 ofs rerst", ofs_level, 8'h80);
    rst_n = 1; am = 0; om = 0;
    // R3 R5 decay with shifts
    amp_shift = 2; ofs_shift = 3;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, i[0], 8'hC0, 8'h90);
      chk_model("R3 R5 ema");
    end
    // R8 shift change between samples
    amp_shift = 15; ofs_shift = 1;
    step(1'b1, 1'b1, 8'h00, 8'h7F);
    chk_model("R8 new shift");
    amp_shift = 0; ofs_shift = 0;
    step(1'b1, 1'b1, 8'h80, 8'h80);
    chk("R8 snap amp", amp_level, 8'h00);
    chk("R8 snap ofs", ofs_level, 8'h80);
    // R5 floor rounding of a small negative offset
    ofs_shift = 1;
    step(1'b1, 1'b1, 8'h80, 8'h7F);
    chk("R5 floor", ofs_level, 8'h7F);
    chk_model("R5 floor model");
    // R6 phase without edge ignored
    step(1'b1, 1'b0, 8'h80, 8'hF0);
    chk("R6 no edge", ofs_level, 8'h7F);
    // R7 extremes held at bounds
    amp_shift = 0; ofs_shift = 0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h00, 8'h00);
    chk("R7 amp max", amp_level, 8'd128);
    chk("R7 ofs min", ofs_level, 8'h00);
    step(1'b1, 1'b1, 8'hFF, 8'hFF);
    chk("R7 ofs max", ofs_level, 8'hFF);
    chk("R2 amp 127", amp_level, 8'd127);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule